// File: doc/BRIEF.md
# Home-Node Directory Coherence Controller

This block is the home directory for the memory blocks held by one node of a small multiprocessor with distributed shared memory. Each block carries a directory entry (uncached, shared or exclusive), a bit vector with one bit per node marking the caches that hold a copy, and the identity of the owning node. The local copy of the block data is kept next to the entries.

Requests reach the block over a valid/ready channel. Each request is a read miss, a write miss or a data write-back, and names the requesting node and a block index. The controller serves one request at a time, so requests are handled in the order they are accepted. It issues invalidate messages to sharers, fetch messages to the current owner, and a data reply to the requester. Each outgoing message uses its own valid/ready channel. When it asks an owner for data, the controller waits for the owner's response before it writes memory and replies.

Control is a six-state machine:
- IDLE accepts a request and moves to DECIDE.
- DECIDE reads the entry. From there, a write-back returns to IDLE. Uncached and shared blocks go to REPLY, or to INVAL when other sharers must be invalidated. An exclusive block goes to FETCH.
- INVAL sends invalidates one at a time and moves to REPLY when none are left.
- FETCH moves to WAIT when the owner accepts the fetch.
- WAIT moves to REPLY when the owner's data arrives.
- REPLY returns to IDLE when the reply is accepted.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every block is uncached with no sharers, all data words are zero, req_ready is 1, and inv_valid, fetch_valid, rply_valid and wb_err are 0.
- R2: A read miss (kind 0) to an uncached block replies with the memory word and leaves the block shared, with the requester as its only sharer. No invalidate or fetch is sent.
- R3: A write miss (kind 1) to an uncached block replies with the memory word and makes the requester the exclusive owner.
- R4: A read miss to a shared block replies with the memory word and adds the requester to the sharer vector. No other message is sent.
- R5: A write miss to a shared block sends one invalidate to every sharer except the requester, in ascending node order and before the reply. It then replies with the memory word and makes the requester the exclusive owner.
- R6: A read miss to an exclusive block sends a fetch to the owner and waits for the owner's data. It writes that data to memory, replies with it, and leaves the block shared by the old owner and the requester.
- R7: A write-back (kind 2) from the owner of an exclusive block writes its data to memory and leaves the block uncached with no sharers. No message is sent.
- R8: A write miss to an exclusive block fetches the data from the owner, writes it to memory and replies with it. The block stays exclusive with the requester as the new owner.
- R9: req_ready is 1 only while the controller is idle and no outgoing message is pending. A request is fully finished before the next one is accepted.
- R10: A write-back that does not come from the owner of an exclusive block leaves memory and the directory unchanged and raises wb_err for exactly one cycle.
- R11: A message whose valid is high while its ready is low stays valid with unchanged contents on the next cycle.
- R12: The reply carries the requester's node number and the requested block index. An invalidate is never addressed to the requester.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and accepting |
| req_kind | input | 2 | 0 read miss, 1 write miss, 2 write-back, 3 ignored |
| req_node | input | NODE_W (2) | Requesting node |
| req_blk | input | IDX_W (4) | Block index |
| req_data | input | DATA_W (32) | Write-back data |
| inv_valid | output | 1 | Invalidate message valid |
| inv_ready | input | 1 | Invalidate accepted |
| inv_node | output | NODE_W (2) | Node to invalidate |
| inv_blk | output | IDX_W (4) | Block to invalidate |
| fetch_valid | output | 1 | Fetch-from-owner message valid |
| fetch_ready | input | 1 | Fetch accepted |
| fetch_node | output | NODE_W (2) | Owner asked for data |
| fetch_blk | output | IDX_W (4) | Block fetched |
| fresp_valid | input | 1 | Owner data response valid |
| fresp_ready | output | 1 | Controller waiting for owner data |
| fresp_data | input | DATA_W (32) | Owner data |
| rply_valid | output | 1 | Data reply valid |
| rply_ready | input | 1 | Data reply accepted |
| rply_node | output | NODE_W (2) | Reply destination (requester) |
| rply_blk | output | IDX_W (4) | Reply block index |
| rply_data | output | DATA_W (32) | Reply data |
| wb_err | output | 1 | One-cycle pulse for a rejected write-back |

## Verification
The assertions assume a well-behaved network:
- A fetch response arrives only while fresp_ready is high.
- Request fields hold steady while req_valid is high.
- A write miss from a node that already owns the block is never issued.

The stimulus respects this. It drives each request for exactly the accepting cycle and raises fresp_valid only after it sees fresp_ready. It builds its sequence of misses and write-backs as a legal coherence history, apart from the write-backs deliberately sent by non-owners. Readies stay high except in one directed test, which holds fetch and reply back for several cycles.

// File: rtl/dirc_pkg.sv
package dirc_pkg;

    typedef enum logic [1:0] {
        DS_UNC = 2'd0,
        DS_SHR = 2'd1,
        DS_EXC = 2'd2
    } dstate_e;

    localparam logic [1:0] RK_READ  = 2'd0;
    localparam logic [1:0] RK_WRITE = 2'd1;
    localparam logic [1:0] RK_WBACK = 2'd2;

    typedef enum logic [2:0] {
        FS_IDLE   = 3'd0,
        FS_DECIDE = 3'd1,
        FS_INVAL  = 3'd2,
        FS_FETCH  = 3'd3,
        FS_WAIT   = 3'd4,
        FS_REPLY  = 3'd5
    } fstate_e;

endpackage

// File: rtl/dirc_dir_table.sv
module dirc_dir_table
    import dirc_pkg::*;
#(
    parameter int NODES  = 4,
    parameter int BLOCKS = 16,
    localparam int NODE_W = $clog2(NODES),
    localparam int IDX_W  = $clog2(BLOCKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output dstate_e           rd_state,
    output logic [NODES-1:0]  rd_sharers,
    output logic [NODE_W-1:0] rd_owner,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  dstate_e           wr_state,
    input  logic [NODES-1:0]  wr_sharers,
    input  logic [NODE_W-1:0] wr_owner
);

    dstate_e           ent_state [BLOCKS];
    logic [NODES-1:0]  ent_shr   [BLOCKS];
    logic [NODE_W-1:0] ent_own   [BLOCKS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < BLOCKS; b++) begin
                ent_state[b] <= DS_UNC;
                ent_shr[b]   <= '0;
                ent_own[b]   <= '0;
            end
        end else if (wr_en) begin
            ent_state[wr_idx] <= wr_state;
            ent_shr[wr_idx]   <= wr_sharers;
            ent_own[wr_idx]   <= wr_owner;
        end
    end

    assign rd_state   = ent_state[rd_idx];
    assign rd_sharers = ent_shr[rd_idx];
    assign rd_owner   = ent_own[rd_idx];

    // R1
    uncached_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_state == DS_UNC) |-> (rd_sharers == '0));

endmodule

// File: rtl/dirc_data_mem.sv
module dirc_data_mem #(
    parameter int BLOCKS = 16,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(BLOCKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data
);

    logic [DATA_W-1:0] words [BLOCKS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < BLOCKS; b++) words[b] <= '0;
        end else if (wr_en) begin
            words[wr_idx] <= wr_data;
        end
    end

    assign rd_data = words[rd_idx];

endmodule

// File: rtl/dirc_ctrl.sv
module dirc_ctrl
    import dirc_pkg::*;
#(
    parameter int NODES  = 4,
    parameter int BLOCKS = 16,
    parameter int DATA_W = 32,
    localparam int NODE_W = $clog2(NODES),
    localparam int IDX_W  = $clog2(BLOCKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic [NODE_W-1:0] req_node,
    input  logic [IDX_W-1:0]  req_blk,
    input  logic [DATA_W-1:0] req_data,
    output logic              inv_valid,
    input  logic              inv_ready,
    output logic [NODE_W-1:0] inv_node,
    output logic [IDX_W-1:0]  inv_blk,
    output logic              fetch_valid,
    input  logic              fetch_ready,
    output logic [NODE_W-1:0] fetch_node,
    output logic [IDX_W-1:0]  fetch_blk,
    input  logic              fresp_valid,
    output logic              fresp_ready,
    input  logic [DATA_W-1:0] fresp_data,
    output logic              rply_valid,
    input  logic              rply_ready,
    output logic [NODE_W-1:0] rply_node,
    output logic [IDX_W-1:0]  rply_blk,
    output logic [DATA_W-1:0] rply_data,
    output logic              wb_err,
    output logic [IDX_W-1:0]  blk_idx,
    input  dstate_e           ent_state,
    input  logic [NODES-1:0]  ent_sharers,
    input  logic [NODE_W-1:0] ent_owner,
    output logic              tbl_we,
    output dstate_e           tbl_state,
    output logic [NODES-1:0]  tbl_sharers,
    output logic [NODE_W-1:0] tbl_owner,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata
);

    localparam logic [NODES-1:0] ONE_BIT = NODES'(1);

    fstate_e           st;
    logic [1:0]        kind_q;
    logic [NODE_W-1:0] node_q;
    logic [IDX_W-1:0]  blk_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic [NODES-1:0]  pend_q;
    logic [NODE_W-1:0] owner_q;

    logic [NODES-1:0]  self_bit;
    logic [NODES-1:0]  others;
    logic [NODE_W-1:0] low_node;
    logic              owner_wb;

    function automatic logic [NODE_W-1:0] lowest_set(input logic [NODES-1:0] m);
        logic [NODE_W-1:0] r;
        r = '0;
        for (int i = NODES - 1; i >= 0; i--) begin
            if (m[i]) r = NODE_W'(i);
        end
        return r;
    endfunction

    assign self_bit = ONE_BIT << node_q;
    assign others   = ent_sharers & ~self_bit;
    assign low_node = lowest_set(pend_q);
    assign owner_wb = (ent_state == DS_EXC) && (ent_owner == node_q);
    assign blk_idx  = blk_q;

    // State register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= FS_IDLE;
            kind_q  <= '0;
            node_q  <= '0;
            blk_q   <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            pend_q  <= '0;
            owner_q <= '0;
        end else begin
            unique case (st)
                FS_IDLE: begin
                    if (req_valid) begin
                        kind_q  <= req_kind;
                        node_q  <= req_node;
                        blk_q   <= req_blk;
                        wdata_q <= req_data;
                        st      <= FS_DECIDE;
                    end
                end
                FS_DECIDE: begin
                    if (kind_q == RK_READ || kind_q == RK_WRITE) begin
                        if (ent_state == DS_EXC) begin
                            owner_q <= ent_owner;
                            st      <= FS_FETCH;
                        end else begin
                            rdata_q <= mem_rdata;
                            if (kind_q == RK_WRITE && ent_state == DS_SHR && others != '0) begin
                                pend_q <= others;
                                st     <= FS_INVAL;
                            end else begin
                                st <= FS_REPLY;
                            end
                        end
                    end else begin
                        st <= FS_IDLE;
                    end
                end
                FS_INVAL: begin
                    if (inv_ready) begin
                        pend_q <= pend_q & ~(ONE_BIT << low_node);
                        if ((pend_q & ~(ONE_BIT << low_node)) == '0) st <= FS_REPLY;
                    end
                end
                FS_FETCH: begin
                    if (fetch_ready) st <= FS_WAIT;
                end
                FS_WAIT: begin
                    if (fresp_valid) begin
                        rdata_q <= fresp_data;
                        st      <= FS_REPLY;
                    end
                end
                FS_REPLY: begin
                    if (rply_ready) st <= FS_IDLE;
                end
            endcase
        end
    end

    // Outputs and directory / memory updates
    always_comb begin
        req_ready   = (st == FS_IDLE);
        inv_valid   = (st == FS_INVAL);
        inv_node    = low_node;
        inv_blk     = blk_q;
        fetch_valid = (st == FS_FETCH);
        fetch_node  = owner_q;
        fetch_blk   = blk_q;
        fresp_ready = (st == FS_WAIT);
        rply_valid  = (st == FS_REPLY);
        rply_node   = node_q;
        rply_blk    = blk_q;
        rply_data   = rdata_q;
        wb_err      = 1'b0;
        tbl_we      = 1'b0;
        tbl_state   = ent_state;
        tbl_sharers = ent_sharers;
        tbl_owner   = ent_owner;
        mem_we      = 1'b0;
        mem_wdata   = wdata_q;
        unique case (st)
            FS_DECIDE: begin
                case (kind_q)
                    RK_READ: begin
                        if (ent_state != DS_EXC) begin
                            tbl_we      = 1'b1;
                            tbl_state   = DS_SHR;
                            tbl_sharers = (ent_state == DS_SHR) ? (ent_sharers | self_bit) : self_bit;
                        end
                    end
                    RK_WRITE: begin
                        if (ent_state != DS_EXC) begin
                            tbl_we      = 1'b1;
                            tbl_state   = DS_EXC;
                            tbl_sharers = self_bit;
                            tbl_owner   = node_q;
                        end
                    end
                    RK_WBACK: begin
                        if (owner_wb) begin
                            tbl_we      = 1'b1;
                            tbl_state   = DS_UNC;
                            tbl_sharers = '0;
                            mem_we      = 1'b1;
                            mem_wdata   = wdata_q;
                        end else begin
                            wb_err = 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
            FS_WAIT: begin
                if (fresp_valid) begin
                    mem_we    = 1'b1;
                    mem_wdata = fresp_data;
                    tbl_we    = 1'b1;
                    if (kind_q == RK_READ) begin
                        tbl_state   = DS_SHR;
                        tbl_sharers = self_bit | (ONE_BIT << owner_q);
                        tbl_owner   = owner_q;
                    end else begin
                        tbl_state   = DS_EXC;
                        tbl_sharers = self_bit;
                        tbl_owner   = node_q;
                    end
                end
            end
            FS_IDLE, FS_INVAL, FS_FETCH, FS_REPLY: ;
        endcase
    end

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !(inv_valid || fetch_valid || rply_valid));

    // R11
    rply_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rply_valid && !rply_ready) |=> (rply_valid && $stable(rply_data) && $stable(rply_node)));

    // R11
    inv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && !inv_ready) |=> (inv_valid && $stable(inv_node)));

    // R11
    fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && !fetch_ready) |=> (fetch_valid && $stable(fetch_node)));

    // R12
    inv_not_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> (inv_node != node_q));

    // R10
    err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_err |=> !wb_err);

    // R6
    fresp_to_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fresp_valid && fresp_ready) |=> (rply_valid && rply_data == $past(fresp_data)));

endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
    import dirc_pkg::*;
#(
    parameter int NODES  = 4,
    parameter int BLOCKS = 16,
    parameter int DATA_W = 32,
    localparam int NODE_W = $clog2(NODES),
    localparam int IDX_W  = $clog2(BLOCKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic [NODE_W-1:0] req_node,
    input  logic [IDX_W-1:0]  req_blk,
    input  logic [DATA_W-1:0] req_data,
    output logic              inv_valid,
    input  logic              inv_ready,
    output logic [NODE_W-1:0] inv_node,
    output logic [IDX_W-1:0]  inv_blk,
    output logic              fetch_valid,
    input  logic              fetch_ready,
    output logic [NODE_W-1:0] fetch_node,
    output logic [IDX_W-1:0]  fetch_blk,
    input  logic              fresp_valid,
    output logic              fresp_ready,
    input  logic [DATA_W-1:0] fresp_data,
    output logic              rply_valid,
    input  logic              rply_ready,
    output logic [NODE_W-1:0] rply_node,
    output logic [IDX_W-1:0]  rply_blk,
    output logic [DATA_W-1:0] rply_data,
    output logic              wb_err
);

    logic [IDX_W-1:0]  blk_idx;
    dstate_e           ent_state;
    logic [NODES-1:0]  ent_sharers;
    logic [NODE_W-1:0] ent_owner;
    logic              tbl_we;
    dstate_e           tbl_state;
    logic [NODES-1:0]  tbl_sharers;
    logic [NODE_W-1:0] tbl_owner;
    logic [DATA_W-1:0] mem_rdata;
    logic              mem_we;
    logic [DATA_W-1:0] mem_wdata;

    dirc_ctrl #(.NODES(NODES), .BLOCKS(BLOCKS), .DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_node(req_node), .req_blk(req_blk), .req_data(req_data),
        .inv_valid(inv_valid), .inv_ready(inv_ready), .inv_node(inv_node), .inv_blk(inv_blk),
        .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
        .fetch_node(fetch_node), .fetch_blk(fetch_blk),
        .fresp_valid(fresp_valid), .fresp_ready(fresp_ready), .fresp_data(fresp_data),
        .rply_valid(rply_valid), .rply_ready(rply_ready), .rply_node(rply_node),
        .rply_blk(rply_blk), .rply_data(rply_data), .wb_err(wb_err),
        .blk_idx(blk_idx), .ent_state(ent_state), .ent_sharers(ent_sharers),
        .ent_owner(ent_owner), .tbl_we(tbl_we), .tbl_state(tbl_state),
        .tbl_sharers(tbl_sharers), .tbl_owner(tbl_owner),
        .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_wdata(mem_wdata)
    );

    dirc_dir_table #(.NODES(NODES), .BLOCKS(BLOCKS)) u_table (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(blk_idx), .rd_state(ent_state), .rd_sharers(ent_sharers), .rd_owner(ent_owner),
        .wr_en(tbl_we), .wr_idx(blk_idx), .wr_state(tbl_state),
        .wr_sharers(tbl_sharers), .wr_owner(tbl_owner)
    );

    dirc_data_mem #(.BLOCKS(BLOCKS), .DATA_W(DATA_W)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(blk_idx), .rd_data(mem_rdata),
        .wr_en(mem_we), .wr_idx(blk_idx), .wr_data(mem_wdata)
    );

endmodule

// File: tb/dir_home_ctrl_tb.sv
module dir_home_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_kind = '0;
    logic [1:0]  req_node = '0;
    logic [3:0]  req_blk = '0;
    logic [31:0] req_data = '0;
    logic        inv_valid;
    logic        inv_ready = 1'b1;
    logic [1:0]  inv_node;
    logic [3:0]  inv_blk;
    logic        fetch_valid;
    logic        fetch_ready = 1'b1;
    logic [1:0]  fetch_node;
    logic [3:0]  fetch_blk;
    logic        fresp_valid = 1'b0;
    logic        fresp_ready;
    logic [31:0] fresp_data = '0;
    logic        rply_valid;
    logic        rply_ready = 1'b1;
    logic [1:0]  rply_node;
    logic [3:0]  rply_blk;
    logic [31:0] rply_data;
    logic        wb_err;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    dir_home_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_node(req_node), .req_blk(req_blk), .req_data(req_data),
        .inv_valid(inv_valid), .inv_ready(inv_ready), .inv_node(inv_node), .inv_blk(inv_blk),
        .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
        .fetch_node(fetch_node), .fetch_blk(fetch_blk),
        .fresp_valid(fresp_valid), .fresp_ready(fresp_ready), .fresp_data(fresp_data),
        .rply_valid(rply_valid), .rply_ready(rply_ready), .rply_node(rply_node),
        .rply_blk(rply_blk), .rply_data(rply_data), .wb_err(wb_err)
    );

    typedef struct packed {
        logic [1:0]  kind;
        logic [1:0]  node;
        logic [3:0]  blk;
        logic [31:0] wdata;
        logic [31:0] fdata;
        logic [3:0]  x_inv;
        logic        x_fetch;
        logic [1:0]  x_fnode;
        logic        x_rply;
        logic [31:0] x_data;
        logic        x_err;
    } vec_t;

    localparam int NV = 16;
    // kind: 0 read miss, 1 write miss, 2 write-back
    localparam vec_t VECS [NV] = '{
        '{2'd0, 2'd0, 4'd3, 32'h0,        32'h0,        4'b0000, 1'b0, 2'd0, 1'b1, 32'h0,        1'b0},
        '{2'd0, 2'd1, 4'd3, 32'h0,        32'h0,        4'b0000, 1'b0, 2'd0, 1'b1, 32'h0,        1'b0},
        '{2'd0, 2'd2, 4'd3, 32'h0,        32'h0,        4'b0000, 1'b0, 2'd0, 1'b1, 32'h0,        1'b0},
        '{2'd1, 2'd1, 4'd3, 32'h0,        32'h0,        4'b0101, 1'b0, 2'd0, 1'b1, 32'h0,        1'b0},
        '{2'd0, 2'd3, 4'd3, 32'h0,        32'hA1A10001, 4'b0000, 1'b1, 2'd1, 1'b1, 32'hA1A10001, 1'b0},
        '{2'd1, 2'd0, 4'd3, 32'h0,        32'h0,        4'b1010, 1'b0, 2'd0, 1'b1, 32'hA1A10001, 1'b0},
        '{2'd1, 2'd2, 4'd3, 32'h0,        32'hB2B20002, 4'b0000, 1'b1, 2'd0, 1'b1, 32'hB2B20002, 1'b0},
        '{2'd2, 2'd1, 4'd3, 32'hDEAD0008, 32'h0,        4'b0000, 1'b0, 2'd0, 1'b0, 32'h0,        1'b1},
        '{2'd2, 2'd2, 4'd3, 32'hC3C30003, 32'h0,        4'b0000, 1'b0, 2'd0, 1'b0, 32'h0,        1'b0},
        '{2'd0, 2'd1, 4'd3, 32'h0,        32'h0,        4'b0000, 1'b0, 2'd0, 1'b1, 32'hC3C30003, 1'b0},
        '{2'd1, 2'd3, 4'd5, 32'h0,        32'h0,        4'b0000, 1'b0, 2'd0, 1'b1, 32'h0,        1'b0},
        '{2'd2, 2'd0, 4'd5, 32'h11110012, 32'h0,        4'b0000, 1'b0, 2'd0, 1'b0, 32'h0,        1'b1},
        '{2'd0, 2'd0, 4'd5, 32'h0,        32'h55550005, 4'b0000, 1'b1, 2'd3, 1'b1, 32'h55550005, 1'b0},
        '{2'd1, 2'd0, 4'd5, 32'h0,        32'h0,        4'b1000, 1'b0, 2'd0, 1'b1, 32'h55550005, 1'b0},
        '{2'd2, 2'd1, 4'd3, 32'h77770015, 32'h0,        4'b0000, 1'b0, 2'd0, 1'b0, 32'h0,        1'b1},
        '{2'd0, 2'd2, 4'd3, 32'h0,        32'h0,        4'b0000, 1'b0, 2'd0, 1'b1, 32'hC3C30003, 1'b0}
    };

    function automatic string tag_of(input int i);
        case (i)
            0, 9:       return "R2";
            10:         return "R3";
            1, 2, 15:   return "R4";
            3, 5, 13:   return "R5";
            4, 12:      return "R6";
            8:          return "R7";
            6:          return "R8";
            default:    return "R10";
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic run_vec(input int i);
        vec_t v;
        logic [3:0]  got_inv;
        bit          order_ok;
        bit          seen_inv;
        logic [1:0]  last_inv;
        bit          got_fetch;
        logic [1:0]  got_fnode;
        bit          got_rply;
        logic [31:0] got_data;
        logic [1:0]  got_rnode;
        logic [3:0]  got_rblk;
        bit          got_err;
        int          err_cycles;
        bit          done;
        string       t;
        v = VECS[i];
        t = tag_of(i);
        got_inv = '0; order_ok = 1'b1; seen_inv = 1'b0; last_inv = '0;
        got_fetch = 1'b0; got_fnode = '0; got_rply = 1'b0; got_data = '0;
        got_rnode = '0; got_rblk = '0; got_err = 1'b0; err_cycles = 0; done = 1'b0;
        @(negedge clk);
        req_kind = v.kind; req_node = v.node; req_blk = v.blk; req_data = v.wdata;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int c = 0; c < 40 && !done; c++) begin
            fresp_valid = 1'b0;
            if (req_ready) begin
                done = 1'b1;
            end else begin
                if (inv_valid) begin
                    if (seen_inv && inv_node <= last_inv) order_ok = 1'b0;
                    if (inv_node == v.node) order_ok = 1'b0;
                    seen_inv = 1'b1;
                    last_inv = inv_node;
                    got_inv[inv_node] = 1'b1;
                    if (got_rply) order_ok = 1'b0;
                end
                if (fetch_valid) begin
                    got_fetch = 1'b1;
                    got_fnode = fetch_node;
                end
                if (fresp_ready) begin
                    fresp_valid = 1'b1;
                    fresp_data  = v.fdata;
                end
                if (rply_valid) begin
                    got_rply  = 1'b1;
                    got_data  = rply_data;
                    got_rnode = rply_node;
                    got_rblk  = rply_blk;
                end
                if (wb_err) begin
                    got_err = 1'b1;
                    err_cycles++;
                end
                @(negedge clk);
            end
        end
        fresp_valid = 1'b0;
        chk(done, "R9", $sformatf("vec %0d returns to idle", i), 32'(done), 32'd1);
        // R5 R12 invalidate set and ordering
        chk(got_inv == v.x_inv, t, $sformatf("vec %0d invalidate set", i), 32'(got_inv), 32'(v.x_inv));
        chk(order_ok, "R5", $sformatf("vec %0d invalidate order", i), 32'(order_ok), 32'd1);
        chk(got_fetch == v.x_fetch, t, $sformatf("vec %0d fetch sent", i), 32'(got_fetch), 32'(v.x_fetch));
        if (v.x_fetch)
            chk(got_fnode == v.x_fnode, t, $sformatf("vec %0d fetch node", i), 32'(got_fnode), 32'(v.x_fnode));
        chk(got_rply == v.x_rply, t, $sformatf("vec %0d reply sent", i), 32'(got_rply), 32'(v.x_rply));
        if (v.x_rply) begin
            chk(got_data == v.x_data, t, $sformatf("vec %0d reply data", i), got_data, v.x_data);
            chk(got_rnode == v.node && got_rblk == v.blk, "R12", $sformatf("vec %0d reply address", i),
                {26'd0, got_rnode, got_rblk}, {26'd0, v.node, v.blk});
        end
        chk(got_err == v.x_err, "R10", $sformatf("vec %0d error flag", i), 32'(got_err), 32'(v.x_err));
        if (v.x_err)
            chk(err_cycles == 1, "R10", $sformatf("vec %0d error pulse width", i), 32'(err_cycles), 32'd1);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1", "req_ready after reset", 32'(req_ready), 32'd1);
        chk({inv_valid, fetch_valid, rply_valid, wb_err} == 4'b0, "R1", "outputs idle after reset",
            32'({inv_valid, fetch_valid, rply_valid, wb_err}), 32'd0);

        for (int i = 0; i < NV; i++) run_vec(i);

        // R11 backpressure on fetch and reply; R9 no acceptance while busy
        // block 5 is exclusive to node 0 here
        fetch_ready = 1'b0;
        rply_ready  = 1'b0;
        @(negedge clk);
        req_kind = 2'd0; req_node = 2'd3; req_blk = 4'd5; req_data = '0;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            chk(fetch_valid && fetch_node == 2'd0 && fetch_blk == 4'd5, "R11", "fetch held under backpressure",
                {28'd0, fetch_valid, fetch_node, 1'b0}, {28'd0, 1'b1, 2'd0, 1'b0});
            chk(!req_ready, "R9", "not ready while fetch pending", 32'(req_ready), 32'd0);
            @(negedge clk);
        end
        fetch_ready = 1'b1;
        @(negedge clk);
        chk(fresp_ready, "R6", "waiting for owner data", 32'(fresp_ready), 32'd1);
        fresp_valid = 1'b1;
        fresp_data  = 32'h66660006;
        @(negedge clk);
        fresp_valid = 1'b0;
        for (int k = 0; k < 3; k++) begin
            chk(rply_valid && rply_data == 32'h66660006 && rply_node == 2'd3, "R11", "reply held under backpressure",
                rply_data, 32'h66660006);
            @(negedge clk);
        end
        rply_ready = 1'b1;
        @(negedge clk);
        chk(req_ready && !rply_valid, "R9", "idle after reply taken",
            32'({req_ready, rply_valid}), 32'b10);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule